// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block turns two parallel audio samples, one for each stereo channel, into the one-bit serial data stream of a standard I2S link. It runs as a slave. An external master supplies the bit clock and the word-select line, and the block only drives the data line. Both samples are signed two's-complement words of `SAMPLE_W` bits, 24 by default.

The word-select input is retimed on the rising edge of the bit clock through a two-stage chain. When the retimed level differs from the previous stage, a one-cycle load strobe is raised. On the next falling edge, the shift register takes the sample of the channel that the retimed level names. On each later falling edge the register moves one place toward its top bit and brings in a zero. The data line is wired straight to the top bit of the register. The most significant bit therefore appears on the falling edge that performs the load, with no extra register stage. After the last bit the line stays low until the next word-select change.

Top module: `i2s_serial_tx`

## Requirements
- R1: With `rst` high at a clock edge, the retiming stages and the shift register clear and `sd_out` is 0. After reset, while `ws_in` stays low, no load happens and `sd_out` stays 0.
- R2: The retimed word-select level picks the channel. Level 0 loads `left_word` and level 1 loads `right_word`. Both words are sent bit-exact, sign bit included.
- R3: When `ws_in` takes a new value that is sampled at rising edge k, the load occurs on the falling edge that follows edge k. The sample's bit `SAMPLE_W-1` is on `sd_out` from that falling edge on. A load strobe arises only when the last two rising-edge samples of `ws_in` differ.
- R4: After a load, each falling edge moves the next lower bit onto `sd_out`, so the word goes out most significant bit first, one bit per bit-clock cycle.
- R5: Zeros are shifted in. After the `SAMPLE_W` bits of a word, `sd_out` stays 0 until the next word-select change.
- R6: The word is captured at the load instant. A change on `left_word` or `right_word` while the word is being shifted out does not alter the bits that follow.
- R7: A word-select change that arrives before the current word has finished reloads the register at once. The new word's MSB replaces the rest of the old word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock from the link master |
| rst | input | 1 | Synchronous reset, active high |
| ws_in | input | 1 | Word-select line from the master (0 = left, 1 = right) |
| left_word | input | SAMPLE_W (24) | Left-channel sample, two's complement |
| right_word | input | SAMPLE_W (24) | Right-channel sample, two's complement |
| sd_out | output | 1 | Serial data line, MSB first |

## Verification
The embedded properties check the following on every cycle:
- a load strobe exists exactly when the last two samples of `ws_in` differ;
- the retimed channel follows the sampled line;
- each load puts the chosen channel's top bit on `sd_out`;
- the number of set bits in the register never grows while it is shifting;
- the line is low once a whole word has gone out.

Some behaviour is visible only over a full stimulus sequence, so only the bench scenarios can show it:
- the sample is captured at the load instant even when the parallel inputs change mid-word;
- an early word-select change truncates a word;
- every bit of every word arrives in the right order.

The bench checks these against a queue-based model, both on every falling edge and through directed checks.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/ws_edge_sync.sv
module ws_edge_sync
  import i2s_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ws_in,
  output chan_e chan,
  output logic  load
);
  logic stage_a_q;
  logic stage_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_a_q <= 1'b0;
      stage_b_q <= 1'b0;
    end else begin
      stage_a_q <= ws_in;
      stage_b_q <= stage_a_q;
    end
  end

  assign load = stage_a_q ^ stage_b_q;
  assign chan = chan_e'(stage_a_q);

  // cycles since reset, saturating at two, used only to arm the checks
  logic [1:0] settle_q;
  always_ff @(posedge clk) begin
    if (rst)                 settle_q <= 2'd0;
    else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
  end

  AST_LOAD_ON_WS_EDGE: assert property (@(posedge clk) disable iff (rst || settle_q != 2'd2)
    load == ($past(ws_in) != $past(ws_in, 2)))
    else $error("load strobe disagrees with ws history"); // R3

  AST_CHAN_FOLLOWS_WS: assert property (@(posedge clk) disable iff (rst || settle_q == 2'd0)
    chan == chan_e'($past(ws_in)))
    else $error("channel select does not follow sampled ws"); // R2
endmodule

// File: rtl/chan_word_mux.sv
module chan_word_mux
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  chan_e               chan,
  input  logic [SAMPLE_W-1:0] left_word,
  input  logic [SAMPLE_W-1:0] right_word,
  output logic [SAMPLE_W-1:0] word
);
  always_comb begin
    unique case (chan)
      CH_RIGHT: word = right_word;
      default:  word = left_word;
    endcase
  end
endmodule

// File: rtl/shift_serializer.sv
module shift_serializer #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] word,
  output logic                sd
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] shreg_q;

  always_ff @(negedge clk) begin
    if (rst)       shreg_q <= '0;
    else if (load) shreg_q <= word;
    else           shreg_q <= {shreg_q[SAMPLE_W-2:0], 1'b0};
  end

  assign sd = shreg_q[SAMPLE_W-1];

  // number of shifts since the last load, for the idle check only
  logic [CNT_W-1:0] shifts_q;
  always_ff @(negedge clk) begin
    if (rst)                 shifts_q <= DONE;
    else if (load)           shifts_q <= '0;
    else if (shifts_q != DONE) shifts_q <= shifts_q + 1'b1;
  end

  AST_IDLE_LINE_LOW: assert property (@(negedge clk) disable iff (rst)
    (shifts_q == DONE) |-> !sd)
    else $error("data line high after word completed"); // R5

  AST_NO_BIT_GROWTH: assert property (@(negedge clk) disable iff (rst)
    !load |=> ($countones(shreg_q) <= $countones($past(shreg_q))))
    else $error("shift introduced a set bit"); // R4
endmodule

// File: rtl/i2s_serial_tx.sv
module i2s_serial_tx
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ws_in,
  input  logic [SAMPLE_W-1:0] left_word,
  input  logic [SAMPLE_W-1:0] right_word,
  output logic                sd_out
);
  chan_e               chan_w;
  logic                load_w;
  logic [SAMPLE_W-1:0] word_w;

  ws_edge_sync u_sync (
    .clk   (clk),
    .rst   (rst),
    .ws_in (ws_in),
    .chan  (chan_w),
    .load  (load_w)
  );

  chan_word_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
    .chan       (chan_w),
    .left_word  (left_word),
    .right_word (right_word),
    .word       (word_w)
  );

  shift_serializer #(.SAMPLE_W(SAMPLE_W)) u_ser (
    .clk  (clk),
    .rst  (rst),
    .load (load_w),
    .word (word_w),
    .sd   (sd_out)
  );

  AST_LOAD_SHOWS_MSB: assert property (@(negedge clk) disable iff (rst)
    load_w |=> (sd_out == $past((chan_w == CH_RIGHT) ? right_word[SAMPLE_W-1]
                                                     : left_word[SAMPLE_W-1])))
    else $error("loaded word MSB not on data line"); // R2
endmodule

// File: tb/i2s_serial_tx_tb.sv
module i2s_serial_tx_tb;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ws_in = 1'b0;
  logic [W-1:0] left_word = '0;
  logic [W-1:0] right_word = '0;
  logic         sd_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2s_serial_tx #(.SAMPLE_W(W)) u_dut (
    .clk(clk), .rst(rst), .ws_in(ws_in),
    .left_word(left_word), .right_word(right_word), .sd_out(sd_out)
  );

  // behavioural reference: recent ws samples and a queue of pending bits
  bit ws_seen[$] = '{1'b0, 1'b0};
  bit pending[$];
  bit model_live = 0;

  always @(posedge clk) begin
    if (rst) ws_seen = '{1'b0, 1'b0};
    else begin
      ws_seen.push_front(ws_in);
      void'(ws_seen.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      pending.delete();
      model_live = 1;
    end else if (ws_seen[0] != ws_seen[1]) begin
      logic [W-1:0] w;
      w = ws_seen[0] ? right_word : left_word;
      pending.delete();
      for (int i = W - 1; i >= 0; i--) pending.push_back(w[i]);
    end else if (pending.size() > 0) begin
      void'(pending.pop_front());
    end
  end

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: sd_out actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R4, R5)
  always @(negedge clk) begin
    #2;
    if (model_live && !done) begin
      logic e;
      e = (pending.size() > 0) ? pending[0] : 1'b0;
      chk(sd_out === e, "R4 model", sd_out, e);
    end
  end

  task automatic go_edge();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    logic [W-1:0] exp_w;
    logic [31:0] seed;
    seed = 32'h1F2E3D4C;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk(sd_out === 1'b0, "R1 reset", sd_out, 1'b0);
    go_edge(); rst = 1'b0;
    repeat (5) @(negedge clk);
    #2 chk(sd_out === 1'b0, "R1 idle after reset", sd_out, 1'b0);

    // R3/R4/R5: right word, MSB timing and bit order
    go_edge();
    right_word = 24'hA5C3E1; exp_w = 24'hA5C3E1; ws_in = 1'b1;
    @(posedge clk); @(negedge clk); #2;
    chk(sd_out === exp_w[W-1], "R3 MSB at first falling edge", sd_out, exp_w[W-1]);
    for (int k = 1; k < W; k++) begin
      @(negedge clk); #2;
      chk(sd_out === exp_w[W-1-k], "R4 bit order", sd_out, exp_w[W-1-k]);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #2;
      chk(sd_out === 1'b0, "R5 idle zero", sd_out, 1'b0);
    end

    // R2 + R6: negative left word, inputs change while shifting
    go_edge();
    left_word = 24'h800000; ws_in = 1'b0;
    @(posedge clk); @(negedge clk); #2;
    chk(sd_out === 1'b1, "R2 left sign bit", sd_out, 1'b1);
    go_edge();
    left_word = 24'h7FFFFF; right_word = 24'hFFFFFF;
    @(negedge clk); #2;
    chk(sd_out === 1'b0, "R6 word held", sd_out, 1'b0);
    @(negedge clk); #2;
    chk(sd_out === 1'b0, "R6 word held", sd_out, 1'b0);
    repeat (30) @(posedge clk);

    // R7: early ws change truncates a word
    go_edge();
    right_word = 24'h123456; ws_in = 1'b1;
    repeat (4) @(posedge clk);
    #1 left_word = 24'hC00000; ws_in = 1'b0;
    @(posedge clk); @(negedge clk); #2;
    chk(sd_out === 1'b1, "R7 reload MSB", sd_out, 1'b1);
    @(negedge clk); #2;
    chk(sd_out === 1'b1, "R7 reload bit22", sd_out, 1'b1);
    @(negedge clk); #2;
    chk(sd_out === 1'b0, "R7 reload bit21", sd_out, 1'b0);
    repeat (30) @(posedge clk);

    // R2: stream of frames with varied samples
    for (int f = 0; f < 12; f++) begin
      go_edge();
      seed = nxt(seed); left_word = seed[W-1:0];
      seed = nxt(seed); right_word = seed[W-1:0];
      ws_in = ~ws_in;
      repeat (32) @(posedge clk);
    end

    // R1: reset in the middle of a word
    go_edge();
    right_word = 24'hFFFFFF; ws_in = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b1;
    @(negedge clk); #2;
    chk(sd_out === 1'b0, "R1 mid-word reset", sd_out, 1'b0);
    go_edge(); rst = 1'b0;
    repeat (40) @(posedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule